// File: doc/BRIEF.md
# Block-Parallel Max-Plus Path Metric Recursion

This block advances the path metrics of an N-state trellis by M trellis steps at a time. Each step arrives as an N×N matrix of branch metrics. Entry (i, j) is the weight of the transition from state j into state i. In max-plus arithmetic, ordinary addition takes the place of multiplication and the maximum takes the place of the sum. One add-compare-select step is therefore a matrix-vector product, and M steps collapse into a single matrix.

The incoming matrices are collected into groups of M. A feed-forward chain of M−1 max-plus matrix multipliers builds the combined M-step matrix. That work sits entirely outside the feedback loop. The loop itself applies the combined matrix to the stored metric vector once per group, so the feedback path runs at 1/M of the step rate and has only one vector-matrix product in it. After each update, the smallest finite metric is subtracted from all metrics.

The block sits between a branch-metric generator and a survivor unit. It takes one matrix per valid beat and returns one metric vector per M accepted beats.

Top module: `mpacs_top`

## Requirements
- R1: While reset is held and right after it is released, `pm_valid_o` is 0, state 0 holds metric 0, and every other state holds the minus-infinity code.
- R2: A metric is 12 bits unsigned, and the code 0xFFF means minus infinity. Matrix entry (destination i, source j) occupies `bm_i[(i*N+j)*12 +: 12]`. The metric of state i occupies `pm_o[i*12 +: 12]`.
- R3: Only beats with `bm_valid_i` high count toward a group. The content of `bm_i` on beats with `bm_valid_i` low has no effect on any later result.
- R4: The metric vector produced for a group equals M successive single-step updates new[i] = max over j of (A[i][j] + old[j]), applied in arrival order, followed by one normalization.
- R5: A sum with a minus-infinity operand is minus infinity, and the maximum ignores minus-infinity operands. A state whose row is entirely minus infinity in the last matrix of a group comes out as 0xFFF.
- R6: Finite sums saturate at 0xFFE.
- R7: After each update, the smallest finite metric is subtracted from every finite metric. If all metrics are minus infinity, they stay minus infinity.
- R8: `pm_valid_o` is high for exactly one cycle per group. It rises at the (M−1)-th rising edge after the edge that accepts the group's last matrix.
- R9: Groups may arrive back to back with no idle beats. Every group produces its own output pulse, and the pulses are M cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bm_valid_i | input | 1 | Beat carries a branch-metric matrix |
| bm_i | input | N*N*12 | One N×N branch-metric matrix, entries packed row-major by destination |
| pm_valid_o | output | 1 | One-cycle pulse when a new metric vector is available |
| pm_o | output | N*12 | Normalized path metrics, state 0 in the lowest field |

## Verification
Some properties are checked by assertions on every cycle. After each update, at least one metric is zero, unless every metric is minus infinity. The output pulse lasts one cycle and follows a combined-matrix strobe. A group strobe never appears without an accepted beat, and two strobes are never adjacent. A state whose row was entirely minus infinity comes out as minus infinity. Whether the numbers themselves are correct can only be shown by the bench scenarios: irregular valid gaps, back-to-back groups, saturation, and the all-minus-infinity case are each compared against a step-by-step scalar model, including the exact cycle of each output pulse.

// File: rtl/mpacs_pkg.sv
package mpacs_pkg;
  localparam int unsigned MW = 12;
  typedef logic [MW-1:0] metric_t;
  localparam metric_t NEG_INF = {MW{1'b1}};
  localparam metric_t SAT_MAX = NEG_INF - metric_t'(1);

  // max-plus product: saturating add, minus infinity absorbs
  function automatic metric_t sat_add(input metric_t a, input metric_t b);
    logic [MW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (a == NEG_INF || b == NEG_INF) return NEG_INF;
    if (s > {1'b0, SAT_MAX}) return SAT_MAX;
    return s[MW-1:0];
  endfunction

  // max-plus sum: maximum, minus infinity is the identity
  function automatic metric_t inf_max(input metric_t a, input metric_t b);
    if (a == NEG_INF) return b;
    if (b == NEG_INF) return a;
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mpacs_matmul.sv
module mpacs_matmul
  import mpacs_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  metric_t lhs_i  [N][N],
  input  metric_t rhs_i  [N][N],
  output metric_t prod_o [N][N]
);
  always_comb begin
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        metric_t acc;
        acc = NEG_INF;
        for (int k = 0; k < N; k++) acc = inf_max(acc, sat_add(lhs_i[r][k], rhs_i[k][c]));
        prod_o[r][c] = acc;
      end
    end
  end
endmodule

// File: rtl/mpacs_loop.sv
module mpacs_loop
  import mpacs_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    step_v_i,
  input  metric_t trans_i [N][N],
  output metric_t pm_o    [N],
  output logic    pm_v_o
);
  metric_t pm_q [N];
  metric_t raw  [N];
  metric_t nxt  [N];
  logic    pm_v_q;

  always_comb begin
    metric_t mn;
    mn = NEG_INF;
    for (int i = 0; i < N; i++) begin
      metric_t acc;
      acc = NEG_INF;
      for (int j = 0; j < N; j++) acc = inf_max(acc, sat_add(trans_i[i][j], pm_q[j]));
      raw[i] = acc;
      if (acc != NEG_INF && acc < mn) mn = acc;
    end
    for (int i = 0; i < N; i++) nxt[i] = (raw[i] == NEG_INF) ? NEG_INF : raw[i] - mn;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm_v_q <= 1'b0;
      for (int i = 0; i < N; i++) pm_q[i] <= (i == 0) ? '0 : NEG_INF;
    end else begin
      pm_v_q <= step_v_i;
      if (step_v_i) pm_q <= nxt;
    end
  end

  assign pm_o   = pm_q;
  assign pm_v_o = pm_v_q;

  logic         has_zero, all_inf;
  logic [N-1:0] inf_vec, dead_row;
  always_comb begin
    has_zero = 1'b0;
    all_inf  = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (pm_q[i] == '0) has_zero = 1'b1;
      if (pm_q[i] != NEG_INF) all_inf = 1'b0;
      inf_vec[i]  = (pm_q[i] == NEG_INF);
      dead_row[i] = 1'b1;
      for (int j = 0; j < N; j++) if (trans_i[i][j] != NEG_INF) dead_row[i] = 1'b0;
    end
  end

  a_r7_normalized: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_v_o |-> (has_zero || all_inf));
  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_v_o |=> !pm_v_o);
  a_r8_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_v_o |-> $past(step_v_i));
  a_r5_dead_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_v_i |=> ((inf_vec & $past(dead_row)) == $past(dead_row)));
endmodule

// File: rtl/mpacs_top.sv
module mpacs_top
  import mpacs_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned M = 4  // steps per group, at least 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bm_valid_i,
  input  logic [N*N*MW-1:0] bm_i,
  output logic              pm_valid_o,
  output logic [N*MW-1:0]   pm_o
);
  localparam int unsigned CW = (M > 1) ? $clog2(M) : 1;

  metric_t in_mat [N][N];
  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) in_mat[i][j] = bm_i[(i*N+j)*MW +: MW];
  end

  // serial-to-parallel collection
  logic [CW-1:0] cnt_q;
  logic          last_beat;
  metric_t       hold_q [M-1][N][N];

  assign last_beat = bm_valid_i && (cnt_q == CW'(M-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (bm_valid_i) cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (bm_valid_i && !last_beat) hold_q[cnt_q] <= in_mat;
  end

  // feed-forward product chain; rest[] carries the matrices still to be folded in
  for (genvar s = 0; s < M-1; s++) begin : g_st
    logic    v;
    metric_t prod [N][N];
    metric_t rest [M][N][N];
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v <= 1'b0;
        else         v <= last_beat;
      end
      always_ff @(posedge clk_i) begin
        if (last_beat) begin
          prod <= hold_q[0];
          for (int k = 0; k < M-1; k++) rest[k] <= hold_q[k];
          rest[M-1] <= in_mat;
        end
      end
    end else begin : g_mid
      metric_t nx [N][N];
      mpacs_matmul #(.N(N)) u_mul (
        .lhs_i  (g_st[s-1].rest[s]),
        .rhs_i  (g_st[s-1].prod),
        .prod_o (nx)
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v <= 1'b0;
        else         v <= g_st[s-1].v;
      end
      always_ff @(posedge clk_i) begin
        if (g_st[s-1].v) begin
          prod <= nx;
          rest <= g_st[s-1].rest;
        end
      end
    end
  end

  metric_t fin_prod [N][N];
  mpacs_matmul #(.N(N)) u_fin (
    .lhs_i  (g_st[M-2].rest[M-1]),
    .rhs_i  (g_st[M-2].prod),
    .prod_o (fin_prod)
  );

  metric_t pm_s [N];
  mpacs_loop #(.N(N)) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_v_i (g_st[M-2].v),
    .trans_i  (fin_prod),
    .pm_o     (pm_s),
    .pm_v_o   (pm_valid_o)
  );

  always_comb begin
    for (int i = 0; i < N; i++) pm_o[i*MW +: MW] = pm_s[i];
  end

  a_r3_head_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_st[0].v |-> $past(bm_valid_i));
  a_r9_group_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_st[0].v |=> !g_st[0].v);
endmodule

// File: tb/mpacs_top_bench.sv
module mpacs_top_bench;
  localparam int N = 4, M = 4, W = 12, INF = 4095, SAT = 4094;

  logic             clk = 1'b0, rst_ni = 1'b0, bm_valid_i = 1'b0;
  logic [N*N*W-1:0] bm_i = '0;
  logic             pm_valid_o;
  logic [N*W-1:0]   pm_o;

  always #5 clk = ~clk;

  mpacs_top #(.N(N), .M(M)) u_mpacs_top (
    .clk_i(clk), .rst_ni(rst_ni), .bm_valid_i(bm_valid_i), .bm_i(bm_i),
    .pm_valid_o(pm_valid_o), .pm_o(pm_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0, e_last = 0;
  bit done = 1'b0;
  int mdl [N];
  int a [N][N];
  logic [N*W-1:0] exp_q [$];
  int             expc_q [$];
  string          tag_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] pack_mdl();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = (mdl[i] < 0) ? 12'hFFF : mdl[i][W-1:0];
    return v;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scalar single-step reference
  task automatic model_step();
    int nw [N];
    for (int i = 0; i < N; i++) begin
      nw[i] = -1;
      for (int j = 0; j < N; j++) begin
        if (a[i][j] != INF && mdl[j] >= 0) begin
          int s;
          s = a[i][j] + mdl[j];
          if (s > SAT) s = SAT;
          if (s > nw[i]) nw[i] = s;
        end
      end
    end
    mdl = nw;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) a[i][j] = (seed*29 + i*13 + j*7) % 61;
  endtask

  task automatic beat();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) bm_i[(i*N+j)*W +: W] = a[i][j][W-1:0];
    bm_valid_i = 1'b1;
    model_step();
    @(negedge clk);
    e_last = cyc;
  endtask

  task automatic idle(input int n);
    bm_valid_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      bm_i = {N*N{12'hA5C}} ^ {(N*N*W/32+1){cyc}};
      @(negedge clk);
    end
  endtask

  task automatic group_done(input string req);
    int mn;
    mn = -1;
    for (int i = 0; i < N; i++) if (mdl[i] >= 0 && (mn < 0 || mdl[i] < mn)) mn = mdl[i];
    if (mn >= 0) for (int i = 0; i < N; i++) if (mdl[i] >= 0) mdl[i] -= mn;
    exp_q.push_back(pack_mdl());
    expc_q.push_back(e_last + M - 1);
    tag_q.push_back(req);
  endtask

  task automatic drain(input string req);
    idle(M + 3);
    chk(exp_q.size() == 0, req, "outputs still pending", exp_q.size(), 0);
  endtask

  // output monitor: value and timing of every pulse
  logic [N*W-1:0] mv;
  int             mc;
  string          mt;
  always @(negedge clk) begin
    if (rst_ni && pm_valid_o && !done) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected pm_valid_o", 1, 0);
      else begin
        mv = exp_q.pop_front();
        mc = expc_q.pop_front();
        mt = tag_q.pop_front();
        chk(pm_o == mv, mt, "metric vector", pm_o, mv);
        chk(cyc == mc, "R8", "pulse cycle", cyc, mc);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  task automatic t_reset();
    bm_valid_i = 1'b0;
    rst_ni = 1'b0;
    mdl[0] = 0;
    for (int i = 1; i < N; i++) mdl[i] = -1;
    repeat (3) @(negedge clk);
    chk(pm_valid_o == 1'b0, "R1", "valid in reset", pm_valid_o, 0);
    chk(pm_o == pack_mdl(), "R1", "metrics in reset", pm_o, pack_mdl());
    rst_ni = 1'b1;
    @(negedge clk);
    chk(pm_valid_o == 1'b0, "R1", "valid after reset", pm_valid_o, 0);
    chk(pm_o[W-1:0] == 12'h000 && pm_o[2*W-1:W] == 12'hFFF, "R2", "field layout",
        pm_o, pack_mdl());
  endtask

  task automatic t_basic();
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s < M; s++) begin fill(b*M + s + 1); beat(); end
      group_done("R4");
      idle(1);
    end
    drain("R4");
  endtask

  task automatic t_gaps();
    fill(11); beat(); idle(2);
    fill(12); beat(); idle(1);
    fill(13); beat(); idle(3);
    chk(pm_valid_o == 1'b0, "R3", "no output before group complete", pm_valid_o, 0);
    fill(14); beat();
    group_done("R3");
    drain("R3");
  endtask

  task automatic t_back();
    for (int b = 0; b < 3; b++) begin
      for (int s = 0; s < M; s++) begin fill(20 + b*M + s); beat(); end
      group_done("R9");
    end
    drain("R9");
  endtask

  task automatic t_neginf();
    fill(40);
    for (int i = 0; i < N; i++) a[i][3] = INF;
    a[0][0] = INF;
    beat();
    fill(41); a[1][1] = INF; beat();
    fill(42); beat();
    fill(43);
    for (int j = 0; j < N; j++) a[2][j] = INF;
    beat();
    group_done("R5");
    drain("R5");
    chk(pm_o[2*W +: W] == 12'hFFF, "R5", "dead state", pm_o[2*W +: W], 12'hFFF);
  endtask

  task automatic t_sat();
    t_reset();
    for (int s = 0; s < M; s++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) a[i][j] = (i == 0) ? ((j == 0) ? 0 : INF) : 2000;
      beat();
    end
    group_done("R6");
    drain("R6");
    chk(pm_o[W +: W] == 12'hFFE, "R6", "saturated metric", pm_o[W +: W], 12'hFFE);
  endtask

  task automatic t_allinf();
    for (int s = 0; s < M; s++) begin
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) a[i][j] = INF;
      beat();
    end
    group_done("R7");
    for (int s = 0; s < M; s++) begin fill(60 + s); beat(); end
    group_done("R7");
    drain("R7");
    chk(pm_o == {N{12'hFFF}}, "R7", "all minus infinity kept", pm_o, {N{12'hFFF}});
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gaps();
    t_back();
    t_neginf();
    t_sat();
    t_allinf();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule